// File: doc/BRIEF.md
# Two-Tier Discharge Overcurrent Hiccup Controller

This block guards a battery pack against excessive discharge current. A digitised reading of the current-sense voltage arrives as an unsigned code, one code step per millivolt by default. The block compares each reading against a low and a high threshold. Each threshold has its own persistence timer, counted in ticks of a slow timebase strobe. These timers stand in for the timing capacitors of an analog protector.

A reading above the low threshold that lasts for the full low-tier blanking time turns the discharge switch off. A reading above the high threshold trips faster, after its own shorter blanking time, and this timer runs in parallel with the low-tier one. After any trip the switch stays off for a restart interval equal to a multiple of the low-tier blanking time. During that interval readings are ignored. The switch then comes back on by itself, and both tiers start counting again from zero. This hiccup behaviour rides through capacitive inrush and still cuts a hard short quickly.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset, `dchg_off`, `cause_low` and `cause_high` are all 0.
- R2: While `sense_code` stays above `LOW_CODE` (150 by default) and the block is not off, `dchg_off` rises on the clock edge that samples the `blank_low`-th `tick`. After one tick fewer, it is still 0.
- R3: A single clock with `sense_code` at or below `LOW_CODE` clears the low-tier count. A full `blank_low` ticks above the threshold are then needed again.
- R4: While `sense_code` stays above `HIGH_CODE` (375 by default), `dchg_off` rises on the edge that samples the `blank_high`-th tick, even though the low-tier count is still running.
- R5: Once off, `dchg_off` falls on the edge that samples the (`off_mult` × `blank_low`)-th tick after the trip. One tick earlier it is still 1.
- R6: While `dchg_off` is 1, readings have no effect. A high reading held through the off interval neither delays the restart nor shortens the next trip: after a restart, a full `blank_low` ticks are needed again.
- R7: On each trip, exactly one of `cause_low` and `cause_high` is set, naming the tier that tripped. If both tiers trip on the same edge, `cause_high` is set. The flags hold until the next trip.
- R8: A reading equal to a threshold does not count as above it.
- R9: Clock cycles with `tick` low do not advance any timer.
- R10: A `blank_low`, `blank_high` or `off_mult` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; each high clock cycle counts as one tick |
| sense_code | input | CODE_W | Sense-voltage reading, unsigned |
| blank_low | input | CNT_W | Low-tier blanking length in ticks |
| blank_high | input | CNT_W | High-tier blanking length in ticks |
| off_mult | input | MULT_W | Restart interval as a multiple of `blank_low` |
| dchg_off | output | 1 | 1 switches the discharge path off; 1 also marks the off interval |
| cause_low | output | 1 | The last trip came from the low tier |
| cause_high | output | 1 | The last trip came from the high tier |

## Verification
Every result depends on one register stage. A trip or a restart shows on `dchg_off` just after the rising edge that samples the deciding tick, and a reading that clears a count takes effect at the next edge. The bench raises `tick` for exactly one clock and changes inputs only on falling edges. It reads outputs at the falling edge after each tick pulse, so both the N−1 and N tick counts are checked on either side of the edge where the change falls due.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_OFF = 1'b1
  } ocp_state_e;

  // A zero-length window behaves as a single tick.
  function automatic logic [31:0] eff_len(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

  // Off interval: multiplier (zero read as one) times effective low-tier window.
  function automatic logic [31:0] restart_ticks(input logic [31:0] blank,
                                                input logic [31:0] mult);
    return eff_len(mult) * eff_len(blank);
  endfunction

  // Strictly above the threshold counts as an excess reading.
  function automatic logic exceeds(input logic [31:0] code,
                                   input logic [31:0] thr);
    return code > thr;
  endfunction

endpackage

// File: rtl/ocp_tier_timer.sv
module ocp_tier_timer #(
  parameter int CODE_W = 10,
  parameter int CNT_W  = 16,
  parameter int THR    = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold,
  input  logic [CODE_W-1:0] sense_code,
  input  logic [CNT_W-1:0]  len,
  output logic              trip
);
  import ocp_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_eff;
  logic             over;
  logic             at_end;

  assign over    = exceeds(32'(sense_code), 32'(THR));
  assign len_eff = CNT_W'(eff_len(32'(len)));
  assign at_end  = (cnt >= len_eff - CNT_W'(1));
  assign trip    = tick & over & ~hold & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold || !over) begin
      cnt <= '0;
    end else if (tick) begin
      if (at_end) cnt <= '0;
      else        cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ocp_restart_timer.sv
module ocp_restart_timer #(
  parameter int CNT_W  = 16,
  parameter int MULT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  logic [CNT_W-1:0]  blank_len,
  input  logic [MULT_W-1:0] mult,
  output logic              done
);
  import ocp_pkg::*;

  localparam int RW = CNT_W + MULT_W;

  logic [RW-1:0] cnt;
  logic [RW-1:0] rlen;
  logic          at_end;

  assign rlen   = RW'(restart_ticks(32'(blank_len), 32'(mult)));
  assign at_end = (cnt >= rlen - RW'(1));
  assign done   = active & tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active || done) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + RW'(1);
    end
  end

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int CODE_W    = 10,
  parameter int CNT_W     = 16,
  parameter int MULT_W    = 5,
  parameter int LOW_CODE  = 150,
  parameter int HIGH_CODE = 375
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] sense_code,
  input  logic [CNT_W-1:0]  blank_low,
  input  logic [CNT_W-1:0]  blank_high,
  input  logic [MULT_W-1:0] off_mult,
  output logic              dchg_off,
  output logic              cause_low,
  output logic              cause_high
);
  import ocp_pkg::*;

  localparam int NTIER = 2;

  ocp_state_e       state;
  logic             hold;
  logic [NTIER-1:0] trip_vec;
  logic             trip_low;
  logic             trip_high;
  logic             restart_done;
  logic [CNT_W-1:0] tier_len [NTIER];

  assign tier_len[0] = blank_low;
  assign tier_len[1] = blank_high;
  assign hold        = (state == ST_OFF);

  for (genvar g = 0; g < NTIER; g++) begin : g_tier
    localparam int THR = (g == 0) ? LOW_CODE : HIGH_CODE;
    ocp_tier_timer #(
      .CODE_W(CODE_W),
      .CNT_W (CNT_W),
      .THR   (THR)
    ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .hold      (hold),
      .sense_code(sense_code),
      .len       (tier_len[g]),
      .trip      (trip_vec[g])
    );
  end

  assign trip_low  = trip_vec[0];
  assign trip_high = trip_vec[1];

  ocp_restart_timer #(
    .CNT_W (CNT_W),
    .MULT_W(MULT_W)
  ) u_restart (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .active   (hold),
    .blank_len(blank_low),
    .mult     (off_mult),
    .done     (restart_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      cause_low  <= 1'b0;
      cause_high <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (trip_high) begin
            state      <= ST_OFF;
            cause_high <= 1'b1;
            cause_low  <= 1'b0;
          end else if (trip_low) begin
            state      <= ST_OFF;
            cause_low  <= 1'b1;
            cause_high <= 1'b0;
          end
        end
        ST_OFF: begin
          if (restart_done) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign dchg_off = (state == ST_OFF);

endmodule

// File: rtl/ocp_hiccup_checker.sv
module ocp_hiccup_checker #(
  parameter int CODE_W    = 10,
  parameter int LOW_CODE  = 150,
  parameter int HIGH_CODE = 375
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CODE_W-1:0] sense_code,
  input logic              dchg_off,
  input logic              cause_low,
  input logic              cause_high,
  input logic              trip_low,
  input logic              trip_high,
  input logic              restart_done
);

  p_trip_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dchg_off) |-> $past(tick));

  p_trip_needs_excess_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dchg_off) |-> ($past(sense_code) > CODE_W'(LOW_CODE)));

  p_high_cause_excess_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dchg_off) && cause_high) |-> ($past(sense_code) > CODE_W'(HIGH_CODE)));

  p_restart_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dchg_off) |-> $past(tick));

  p_restart_only_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_done |-> dchg_off);

  p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cause_low, cause_high}));

  p_off_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dchg_off |-> (cause_low || cause_high));

  p_tie_high_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dchg_off && trip_low && trip_high) |=> cause_high);

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_checker #(
  .CODE_W   (CODE_W),
  .LOW_CODE (LOW_CODE),
  .HIGH_CODE(HIGH_CODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .sense_code  (sense_code),
  .dchg_off    (dchg_off),
  .cause_low   (cause_low),
  .cause_high  (cause_high),
  .trip_low    (trip_low),
  .trip_high   (trip_high),
  .restart_done(restart_done)
);

// File: tb/ocp_hiccup_ctrl_bench.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl_bench;
  localparam int CODE_W = 10;
  localparam int CNT_W  = 16;
  localparam int MULT_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [CODE_W-1:0] sense_code = '0;
  logic [CNT_W-1:0]  blank_low = 16'd5;
  logic [CNT_W-1:0]  blank_high = 16'd2;
  logic [MULT_W-1:0] off_mult = 5'd3;
  logic              dchg_off, cause_low, cause_high;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ocp_hiccup_ctrl u_ocp_hiccup_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sense_code(sense_code),
    .blank_low(blank_low), .blank_high(blank_high), .off_mult(off_mult),
    .dchg_off(dchg_off), .cause_low(cause_low), .cause_high(cause_high)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Return to the on state with a quiet reading: 3*5 ticks is the off interval.
  task automatic recover();
    sense_code = 10'd0;
    ticks(15);
    chk("R5 recover", dchg_off, 0);
  endtask

  task automatic t_reset();
    chk("R1 dchg_off", dchg_off, 0);
    chk("R1 cause_low", cause_low, 0);
    chk("R1 cause_high", cause_high, 0);
  endtask

  task automatic t_low_trip_and_hiccup();
    sense_code = 10'd200;
    ticks(4);
    chk("R2 before window", dchg_off, 0);
    ticks(1);
    chk("R2 trip", dchg_off, 1);
    chk("R7 cause_low", cause_low, 1);
    chk("R7 cause_high", cause_high, 0);
    ticks(14);
    chk("R5 still off", dchg_off, 1);
    chk("R6 still off under load", dchg_off, 1);
    ticks(1);
    chk("R5 restored", dchg_off, 0);
    ticks(4);
    chk("R6 fresh window", dchg_off, 0);
    ticks(1);
    chk("R6 retrip", dchg_off, 1);
    recover();
  endtask

  task automatic t_dip_clears();
    sense_code = 10'd200;
    ticks(3);
    sense_code = 10'd150;   // equal to threshold: not above (R8)
    idle(1);
    sense_code = 10'd200;
    ticks(4);
    chk("R3 count cleared", dchg_off, 0);
    ticks(1);
    chk("R3 trip after full window", dchg_off, 1);
    recover();
  endtask

  task automatic t_high_trip();
    sense_code = 10'd400;
    ticks(1);
    chk("R4 before window", dchg_off, 0);
    ticks(1);
    chk("R4 trip", dchg_off, 1);
    chk("R7 cause_high", cause_high, 1);
    chk("R7 cause_low cleared", cause_low, 0);
    recover();
    chk("R7 flag held", cause_high, 1);
  endtask

  task automatic t_equal_threshold();
    sense_code = 10'd150;
    ticks(10);
    chk("R8 equal low", dchg_off, 0);
    blank_low = 16'd1;
    sense_code = 10'd375;   // above low, equal high: only low tier may trip
    ticks(1);
    chk("R8 equal high is low cause", cause_low, 1);
    blank_low = 16'd5;
    recover();
  endtask

  task automatic t_no_tick();
    sense_code = 10'd200;
    idle(50);
    chk("R9 no tick no trip", dchg_off, 0);
    ticks(4);
    chk("R9 count unchanged", dchg_off, 0);
    ticks(1);
    chk("R9 trip", dchg_off, 1);
    recover();
  endtask

  task automatic t_zero_lengths();
    blank_low = 16'd0;
    off_mult = 5'd0;
    sense_code = 10'd200;
    ticks(1);
    chk("R10 zero window trips in one", dchg_off, 1);
    sense_code = 10'd0;
    ticks(1);
    chk("R10 zero restart in one", dchg_off, 0);
    blank_low = 16'd5;
    off_mult = 5'd3;
  endtask

  task automatic t_tie();
    blank_low = 16'd2;
    blank_high = 16'd2;
    sense_code = 10'd400;
    ticks(2);
    chk("R7 tie trip", dchg_off, 1);
    chk("R7 tie high wins", cause_high, 1);
    chk("R7 tie low clear", cause_low, 0);
    sense_code = 10'd0;
    ticks(6);
    chk("R5 tie restore", dchg_off, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    t_reset();
    t_low_trip_and_hiccup();
    t_dip_clears();
    t_high_trip();
    t_equal_threshold();
    t_no_tick();
    t_zero_lengths();
    t_tie();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule